// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Port with Collision and Mode-Fault Detection

This block is a byte-oriented synchronous serial port that runs either as the clock-generating side (master) or as the clock-receiving side (slave). In every frame it sends one word and receives one word at the same time, most significant bit first, over a data-out line, a data-in line and a shared serial clock. As master it derives the serial clock from the system clock through a power-of-two divider. As slave it follows an external serial clock and a low-active select line, both of which it resynchronises into the system clock domain.

Software uses a small register port with three registers: configuration, status and data. Writing the data register loads the transmit shifter and, in master mode, starts a frame. A completed word is moved into a read buffer, so the next frame can begin before software collects the previous word. Two error cases are detected in hardware. A data write that arrives while a frame is running is refused and flagged as a collision. A low select input seen while the block is the enabled master is flagged as a mode fault, and the fault also removes the block from master mode so that it stops driving the clock and data lines.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: After reset the configuration (address 0) and status (address 1) registers read 8'h00, and irq, sck_oe, mosi_oe and miso_oe are all low.
- R2: A frame exchanges one 8-bit word in each direction, MSB first. The master receives the word loaded into the slave, the slave receives the master's word, and with mosi_o looped back to miso_i the master receives its own word. The received word is read from the data register (address 2).
- R3: Configuration bit 2 (cpol) sets the level of sck_o between frames. A master frame makes exactly 16 transitions on sck_o and ends at that level.
- R4: Configuration bit 3 (cpha) picks the capture edge. With cpha=0 the MSB is on the data output before the first clock edge, data is captured on odd edges and the next bit appears on even edges. With cpha=1 the output changes on odd edges from the third edge on and data is captured on even edges. After the second edge the master output therefore carries bit 6 when cpha=0 and still bit 7 when cpha=1.
- R5: In master mode the rate field, configuration bits 6:4 with value s, gives 2^s system clocks per serial half period. The done flag becomes visible 16*2^s+1 clocks after the clock edge that takes the data write.
- R6: In slave mode the rate field has no effect: the frame is timed only by the received sck_i, and data is exchanged correctly whatever the slave's rate field holds.
- R7: Status bit 0 (done) is set when a frame completes. irq equals configuration bit 7 (interrupt enable) ANDed with the OR of done and fault.
- R8: The done and collision flags are cleared only by a status read followed by a data register access. A data read without a preceding status read leaves them set.
- R9: A data write during a frame (master active, or slave selected) sets status bit 1 (collision) and changes neither the word being sent nor the word being received.
- R10: While the block is the enabled master (configuration bits 0 and 1 both set), a low ss_n_i sets status bit 2 (fault) and clears those two bits, which releases sck_oe and mosi_oe. The fault flag is cleared by a status read followed by a configuration write.
- R11: The received word stays in the read buffer until the next frame completes, so it can be read while a following frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read arms flag clearing) |
| bus_addr | input | 2 | Register select: 0 configuration, 1 status, 2 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the remote master (slave mode) |
| sck_o | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Drive enable for sck_o |
| ss_n_i | input | 1 | Low-active select; a slave is selected by it, and an enabled master takes a low level as a mode fault |
| mosi_i | input | 1 | Serial data in while slave |
| mosi_o | output | 1 | Serial data out while master |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data in while master |
| miso_o | output | 1 | Serial data out while slave |
| miso_oe | output | 1 | Drive enable for miso_o |

## Verification
The two error paths are the hardest situations to reach. A collision needs a data write that lands inside a running frame, so the bench starts a slow frame, issues a second data write a fixed number of cycles later, and then confirms through the data register that the original word completed unchanged. A mode fault needs the select line pulled low while the block is an enabled master, which the bench drives directly before reading the configuration back. Slave behaviour is reached by wiring a second instance as a slave to the block under test, with randomised clock modes and a randomised (and meant to be ignored) rate field on the slave.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;

  localparam int unsigned RATE_W = 3;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  // bit 7 irq_en, bits 6:4 rate, bit 3 cpha, bit 2 cpol, bit 1 master, bit 0 en
  typedef struct packed {
    logic              irq_en;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } cfg_t;

  // System clocks per serial half period for a given rate code.
  function automatic int unsigned sck_half(input logic [RATE_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  // Odd edges (1-based) are leading edges; capture on them when cpha is 0.
  function automatic logic is_capture_edge(input logic cpha, input logic odd_edge);
    return cpha ? !odd_edge : odd_edge;
  endfunction

endpackage

// File: rtl/spi_duplex_sync.sv
module spi_duplex_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/spi_duplex_clkgen.sv
module spi_duplex_clkgen
  import spi_duplex_pkg::*;
#(
  parameter int unsigned EDGES = 16,
  localparam int unsigned IDX_W = $clog2(EDGES + 1),
  localparam int unsigned DIV_W = 2 ** RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cpol,
  input  logic [RATE_W-1:0] rate,
  output logic              active,
  output logic              tick,
  output logic [IDX_W-1:0]  tick_idx,
  output logic              sck
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] half_m1;
  logic [IDX_W-1:0] edge_cnt;
  logic             last_edge;

  assign half_m1   = DIV_W'(sck_half(rate) - 32'd1);
  assign tick      = active && (div_cnt == half_m1);
  assign tick_idx  = edge_cnt + 1'b1;
  assign last_edge = (tick_idx == IDX_W'(EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sck      <= 1'b0;
    end else if (abort) begin
      active   <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sck      <= cpol;
    end else if (start) begin
      active   <= 1'b1;
      div_cnt  <= '0;
      edge_cnt <= '0;
      sck      <= cpol;
    end else if (active) begin
      if (tick) begin
        div_cnt <= '0;
        sck     <= ~sck;
        if (last_edge) begin
          active   <= 1'b0;
          edge_cnt <= '0;
        end else begin
          edge_cnt <= tick_idx;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end else begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_duplex_shifter.sv
module spi_duplex_shifter
  import spi_duplex_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned EDGES = 2 * DATA_W,
  localparam int unsigned IDX_W = $clog2(EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              ev,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic              cpha,
  input  logic              din,
  output logic              sout,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              capture;
  logic              first_edge;
  logic              last_edge;

  assign capture    = is_capture_edge(cpha, ev_idx[0]);
  assign first_edge = (ev_idx == IDX_W'(1));
  assign last_edge  = (ev_idx == IDX_W'(EDGES));
  assign sout       = tx_sh[DATA_W-1];
  assign rx_word    = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      done  <= 1'b0;
    end else begin
      done <= ev && last_edge;
      if (load) begin
        tx_sh <= load_val;
      end else if (ev) begin
        if (capture) begin
          rx_sh <= {rx_sh[DATA_W-2:0], din};
        end else if (!(cpha && first_edge)) begin
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_duplex_regs.sv
module spi_duplex_regs
  import spi_duplex_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic              fault_ev,
  input  logic [DATA_W-1:0] rx_word,
  output cfg_t              cfg,
  output logic              data_wr,
  output logic              coll_ev,
  output logic              done_flag,
  output logic              coll_flag,
  output logic              fault_flag,
  output logic [DATA_W-1:0] rbuf,
  output logic              irq
);
  logic wr_cfg;
  logic rd_stat;
  logic data_acc;
  logic armed;
  cfg_t cfg_nxt;
  logic [7:0] stat_byte;

  assign wr_cfg   = bus_wr && (bus_addr == REG_CFG);
  assign rd_stat  = bus_rd && (bus_addr == REG_STAT);
  assign data_wr  = bus_wr && (bus_addr == REG_DATA);
  assign data_acc = (bus_wr || bus_rd) && (bus_addr == REG_DATA);
  assign coll_ev  = data_wr && busy;
  assign stat_byte = {5'b0, fault_flag, coll_flag, done_flag};
  assign irq      = cfg.irq_en && (done_flag || fault_flag);

  always_comb begin
    cfg_nxt = wr_cfg ? cfg_t'(bus_wdata[7:0]) : cfg;
    if (fault_ev) begin
      cfg_nxt.en     = 1'b0;
      cfg_nxt.master = 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CFG:  bus_rdata = DATA_W'(cfg);
      REG_STAT: bus_rdata = DATA_W'(stat_byte);
      REG_DATA: bus_rdata = rbuf;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      armed      <= 1'b0;
      done_flag  <= 1'b0;
      coll_flag  <= 1'b0;
      fault_flag <= 1'b0;
      rbuf       <= '0;
    end else begin
      cfg <= cfg_nxt;

      if (rd_stat)                  armed <= 1'b1;
      else if (data_acc || wr_cfg)  armed <= 1'b0;

      if (xfer_done)                done_flag <= 1'b1;
      else if (armed && data_acc)   done_flag <= 1'b0;

      if (coll_ev)                  coll_flag <= 1'b1;
      else if (armed && data_acc)   coll_flag <= 1'b0;

      if (fault_ev)                 fault_flag <= 1'b1;
      else if (armed && wr_cfg)     fault_flag <= 1'b0;

      if (xfer_done)                rbuf <= rx_word;
    end
  end
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
  import spi_duplex_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned IDX_W = $clog2(EDGES + 1);

  cfg_t              cfg;
  logic              ss_s;
  logic              sck_s;
  logic              sck_prev;
  logic              is_master;
  logic              slave_sel;
  logic              fault_ev;
  logic              busy;
  logic              data_wr;
  logic              coll_ev;
  logic              load;
  logic              m_start;
  logic              m_abort;
  logic              m_active;
  logic              m_tick;
  logic [IDX_W-1:0]  m_idx;
  logic              m_sck;
  logic              s_edge;
  logic [IDX_W-1:0]  s_cnt;
  logic [IDX_W-1:0]  s_idx;
  logic              ev;
  logic [IDX_W-1:0]  ev_idx;
  logic              din;
  logic              sout;
  logic              xfer_done;
  logic [DATA_W-1:0] rx_word;
  logic              done_flag;
  logic              coll_flag;
  logic              fault_flag;
  logic [DATA_W-1:0] rbuf;
  logic              cfg_cpol;

  spi_duplex_sync #(.RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ss_n_i), .q_sync(ss_s)
  );

  spi_duplex_sync #(.RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sck_i), .q_sync(sck_s)
  );

  assign cfg_cpol  = cfg.cpol;
  assign is_master = cfg.en && cfg.master;
  assign slave_sel = cfg.en && !cfg.master && !ss_s;
  assign fault_ev  = is_master && !ss_s;
  assign busy      = m_active || slave_sel;
  assign load      = data_wr && !busy;
  assign m_start   = load && is_master && ss_s;
  assign m_abort   = fault_ev || !is_master;

  spi_duplex_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .xfer_done(xfer_done), .fault_ev(fault_ev), .rx_word(rx_word),
    .cfg(cfg), .data_wr(data_wr), .coll_ev(coll_ev),
    .done_flag(done_flag), .coll_flag(coll_flag), .fault_flag(fault_flag),
    .rbuf(rbuf), .irq(irq)
  );

  spi_duplex_clkgen #(.EDGES(EDGES)) u_clkgen (
    .clk(clk), .rst_n(rst_n),
    .start(m_start), .abort(m_abort),
    .cpol(cfg.cpol), .rate(cfg.rate),
    .active(m_active), .tick(m_tick), .tick_idx(m_idx), .sck(m_sck)
  );

  // Slave edge tracking on the resynchronised serial clock.
  assign s_edge = slave_sel && (sck_s ^ sck_prev);
  assign s_idx  = s_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      s_cnt    <= '0;
    end else begin
      sck_prev <= sck_s;
      if (!slave_sel)  s_cnt <= '0;
      else if (s_edge) s_cnt <= (s_idx == IDX_W'(EDGES)) ? '0 : s_idx;
    end
  end

  assign ev     = m_active ? m_tick : s_edge;
  assign ev_idx = m_active ? m_idx  : s_idx;
  assign din    = m_active ? miso_i : mosi_i;

  spi_duplex_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_val(bus_wdata),
    .ev(ev), .ev_idx(ev_idx), .cpha(cfg.cpha), .din(din),
    .sout(sout), .done(xfer_done), .rx_word(rx_word)
  );

  assign sck_o   = m_sck;
  assign sck_oe  = is_master;
  assign mosi_o  = sout;
  assign mosi_oe = is_master;
  assign miso_o  = sout;
  assign miso_oe = slave_sel;
endmodule

// File: rtl/spi_duplex_sva.sv
module spi_duplex_sva #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned EDGES = 2 * DATA_W,
  localparam int unsigned IDX_W = $clog2(EDGES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpol,
  input logic              sck_o,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic              m_active,
  input logic              m_tick,
  input logic [IDX_W-1:0]  m_idx,
  input logic              data_wr,
  input logic              fault_flag,
  input logic              done_flag,
  input logic              xfer_done,
  input logic [DATA_W-1:0] rbuf
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_active && $past(!m_active) && $stable(cpol)) |-> (sck_o == cpol)); // R3

  AST_EDGE_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    m_active |-> (m_idx <= IDX_W'(EDGES))); // R3

  AST_FAULT_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> (!sck_oe && !mosi_oe)); // R10

  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(xfer_done)); // R7

  AST_RBUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |=> $stable(rbuf)); // R11

  AST_WRITE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (m_active && data_wr && !m_tick) |=> (!sck_oe || $stable(m_idx))); // R9
endmodule

bind spi_duplex_ctrl spi_duplex_sva #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .sck_o(sck_o), .sck_oe(sck_oe),
  .mosi_oe(mosi_oe), .m_active(m_active), .m_tick(m_tick), .m_idx(m_idx),
  .data_wr(data_wr), .fault_flag(fault_flag), .done_flag(done_flag),
  .xfer_done(xfer_done), .rbuf(rbuf)
);

// File: tb/spi_duplex_ctrl_test.sv
module spi_duplex_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic       u_wr = 0, u_rd = 0, p_wr = 0, p_rd = 0;
  logic [1:0] u_addr = 0, p_addr = 0;
  logic [7:0] u_wdata = 0, p_wdata = 0, u_rdata, p_rdata;
  logic       u_irq, p_irq;
  logic       u_sck, u_sck_oe, p_sck, p_sck_oe;
  logic       u_mosi, u_mosi_oe, p_mosi, p_mosi_oe;
  logic       u_miso, u_miso_oe, p_miso, p_miso_oe;
  logic       u_ss_n = 1'b1, p_ss_n = 1'b1;
  logic       loop_sel = 1'b1;
  logic       u_miso_in;
  assign u_miso_in = loop_sel ? u_mosi : p_miso;

  spi_duplex_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(u_wr), .bus_rd(u_rd), .bus_addr(u_addr),
    .bus_wdata(u_wdata), .bus_rdata(u_rdata), .irq(u_irq),
    .sck_i(p_sck), .sck_o(u_sck), .sck_oe(u_sck_oe), .ss_n_i(u_ss_n),
    .mosi_i(p_mosi), .mosi_o(u_mosi), .mosi_oe(u_mosi_oe),
    .miso_i(u_miso_in), .miso_o(u_miso), .miso_oe(u_miso_oe)
  );

  spi_duplex_ctrl peer (
    .clk(clk), .rst_n(rst_n), .bus_wr(p_wr), .bus_rd(p_rd), .bus_addr(p_addr),
    .bus_wdata(p_wdata), .bus_rdata(p_rdata), .irq(p_irq),
    .sck_i(u_sck), .sck_o(p_sck), .sck_oe(p_sck_oe), .ss_n_i(p_ss_n),
    .mosi_i(u_mosi), .mosi_o(p_mosi), .mosi_oe(p_mosi_oe),
    .miso_i(1'b0), .miso_o(p_miso), .miso_oe(p_miso_oe)
  );

  localparam logic [1:0] A_CFG = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  int  tog = 0;
  bit  tog_en = 0;
  always @(posedge u_sck or negedge u_sck) if (tog_en) tog++;

  function automatic logic [7:0] cfg_byte(input bit en, input bit mst, input bit cpol,
                                          input bit cpha, input logic [2:0] rate, input bit ie);
    return {ie, rate, cpha, cpol, mst, en};
  endfunction

  function automatic int done_delay(input logic [2:0] sel);
    return 16 * (1 << sel);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int which, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (which == 0) begin u_wr = 1; u_addr = a; u_wdata = d; end
    else            begin p_wr = 1; p_addr = a; p_wdata = d; end
    @(negedge clk);
    u_wr = 0; p_wr = 0;
  endtask

  task automatic reg_rd(input int which, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    if (which == 0) begin u_rd = 1; u_addr = a; end
    else            begin p_rd = 1; p_addr = a; end
    #1;
    d = (which == 0) ? u_rdata : p_rdata;
    @(negedge clk);
    u_rd = 0; p_rd = 0;
  endtask

  task automatic wait_irq(input string req, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (u_irq) return;
    end
    check(req, 32'd0, 32'd1);
  endtask

  // Master frame with mosi looped back into miso.
  task automatic loop_frame(input bit cpol, input bit cpha, input logic [2:0] sel,
                            input logic [7:0] a, output logic [7:0] r);
    logic [7:0] s;
    loop_sel = 1'b1;
    reg_wr(0, A_CFG, cfg_byte(1, 1, cpol, cpha, sel, 1));
    reg_wr(0, A_DATA, a);
    wait_irq("R7", done_delay(sel) + 20);
    reg_rd(0, A_STAT, s);
    check("R7", s, 8'h01);
    reg_rd(0, A_DATA, r);
  endtask

  task automatic exchange(input bit cpol, input bit cpha, input logic [2:0] msel,
                          input logic [2:0] psel, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] s, r;
    loop_sel = 1'b0;
    reg_wr(0, A_CFG, cfg_byte(1, 1, cpol, cpha, msel, 1));
    reg_wr(1, A_CFG, cfg_byte(1, 0, cpol, cpha, psel, 0));
    reg_wr(1, A_DATA, b);
    @(negedge clk); p_ss_n = 1'b0;
    repeat (4) @(negedge clk);
    reg_wr(0, A_DATA, a);
    wait_irq("R7", done_delay(msel) + 20);
    repeat (8) @(negedge clk);
    p_ss_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_rd(0, A_STAT, s);
    reg_rd(0, A_DATA, r);
    check("R2 master rx", r, b);
    reg_rd(1, A_STAT, s);
    check("R7 slave done", s[0], 1'b1);
    reg_rd(1, A_DATA, r);
    check("R6 slave rx", r, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r, s;
    int unsigned seed;
    seed = $urandom(32'h5E1D_2024);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    reg_rd(0, A_CFG, r);  check("R1 cfg", r, 8'h00);
    reg_rd(0, A_STAT, r); check("R1 stat", r, 8'h00);
    check("R1 pins", {u_irq, u_sck_oe, u_mosi_oe, u_miso_oe}, 4'b0000);

    // R4: edge phase, output after second edge
    for (int ph = 0; ph < 2; ph++) begin
      loop_sel = 1'b1;
      reg_wr(0, A_CFG, cfg_byte(1, 1, 0, ph[0], 3'd3, 1));
      reg_wr(0, A_DATA, 8'hA5);
      check("R4 msb first", u_mosi, 1'b1);
      repeat (2 * 8) @(posedge clk);
      #2;
      check("R4 after edge 2", u_mosi, (ph == 0) ? 1'b0 : 1'b1);
      wait_irq("R4", 200);
      reg_rd(0, A_STAT, s);
      reg_rd(0, A_DATA, r);
      check("R4 data", r, 8'hA5);
    end

    // R5 and R3: rate timing, idle level and edge count
    for (int sel = 0; sel < 5; sel++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] a;
        a = 8'($urandom);
        loop_sel = 1'b1;
        reg_wr(0, A_CFG, cfg_byte(1, 1, pol[0], sel[0], 3'(sel), 1));
        repeat (2) @(negedge clk);
        check("R3 idle level", u_sck, pol[0]);
        tog = 0; tog_en = 1;
        reg_wr(0, A_DATA, a);
        repeat (done_delay(3'(sel))) @(posedge clk);
        #2 check("R5 not yet done", u_irq, 1'b0);
        @(posedge clk);
        #2 check("R5 done on time", u_irq, 1'b1);
        tog_en = 0;
        check("R3 transitions", tog, 16);
        check("R3 end level", u_sck, pol[0]);
        reg_rd(0, A_STAT, s);
        reg_rd(0, A_DATA, r);
        check("R2 loopback", r, a);
      end
    end

    // R8: data read alone does not clear done
    loop_sel = 1'b1;
    reg_wr(0, A_CFG, cfg_byte(1, 1, 1, 0, 3'd1, 1));
    reg_wr(0, A_DATA, 8'h96);
    wait_irq("R8", 100);
    reg_rd(0, A_DATA, r);
    check("R2 loopback", r, 8'h96);
    reg_rd(0, A_STAT, s);
    check("R8 done kept", s, 8'h01);
    reg_rd(0, A_DATA, r);
    reg_rd(0, A_STAT, s);
    check("R8 done cleared", s, 8'h00);

    // R9: collision during a frame
    reg_wr(0, A_CFG, cfg_byte(1, 1, 0, 1, 3'd3, 1));
    reg_wr(0, A_DATA, 8'h3C);
    repeat (20) @(negedge clk);
    reg_wr(0, A_DATA, 8'hFF);
    reg_rd(0, A_STAT, s);
    check("R9 collision flag", s, 8'h02);
    wait_irq("R9", 200);
    reg_rd(0, A_STAT, s);
    check("R9 flags", s, 8'h03);
    reg_rd(0, A_DATA, r);
    check("R9 data unaffected", r, 8'h3C);
    reg_rd(0, A_STAT, s);
    check("R8 collision cleared", s, 8'h00);

    // R11: read buffer holds old word during next frame
    reg_wr(0, A_CFG, cfg_byte(1, 1, 0, 0, 3'd3, 1));
    reg_wr(0, A_DATA, 8'h5A);
    wait_irq("R11", 200);
    reg_wr(0, A_DATA, 8'hC3);
    repeat (40) @(negedge clk);
    reg_rd(0, A_DATA, r);
    check("R11 old word", r, 8'h5A);
    repeat (200) @(negedge clk);
    reg_rd(0, A_STAT, s);
    reg_rd(0, A_DATA, r);
    check("R11 new word", r, 8'hC3);

    // R10: mode fault
    reg_wr(0, A_CFG, cfg_byte(1, 1, 0, 0, 3'd3, 1));
    u_ss_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 irq", u_irq, 1'b1);
    check("R10 released", {u_sck_oe, u_mosi_oe}, 2'b00);
    reg_rd(0, A_CFG, r);
    check("R10 cfg", r, cfg_byte(0, 0, 0, 0, 3'd3, 1));
    reg_rd(0, A_STAT, s);
    check("R10 fault flag", s, 8'h04);
    u_ss_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_rd(0, A_STAT, s);
    reg_wr(0, A_CFG, 8'h00);
    reg_rd(0, A_STAT, s);
    check("R10 fault cleared", s, 8'h00);

    // R2, R6: random master/slave exchanges
    for (int n = 0; n < 12; n++) begin
      exchange(1'($urandom), 1'($urandom), 3'(3 + ($urandom % 2)),
               3'($urandom), 8'($urandom), 8'($urandom));
    end
    exchange(0, 0, 3'd3, 3'd0, 8'h80, 8'h01);
    exchange(1, 1, 3'd4, 3'd7, 8'hFF, 8'h00);

    // R2: fast loopback frames
    for (int n = 0; n < 6; n++) begin
      logic [7:0] a;
      a = 8'($urandom);
      loop_frame(1'($urandom), 1'($urandom), 3'($urandom % 3), a, r);
      check("R2 fast loopback", r, a);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule